// File: doc/BRIEF.md
# Byte ALU with Condition-Code Update

This block is the arithmetic and logic core of an 8-bit accumulator machine. Each accepted request carries an operation code, two operand bytes and the current condition-code byte. One clock later it returns the result byte, the new condition codes, a mask of the flags the operation updated, and a write strobe that says whether the result should be written back to its destination.

The condition codes are five bits: half-carry, negative, zero, overflow and carry. Each operation has its own rule for these flags. Some flags are computed, some are forced to fixed values, and the rest are passed through from the incoming flag byte. Operand fetching, addressing, register storage and instruction decode belong to the surrounding datapath.

Top module: `alu8_cc`

## Requirements
- R1: After reset, and in any cycle that follows one with `in_valid` low, `out_valid`, `wr_en` and `upd_mask` are 0. At reset, `res` and `flags_out` are 0.
- R2: A request taken with `in_valid` high appears on the outputs one cycle later, with `out_valid` high. Flag bits are H=bit4, N=bit3, Z=bit2, V=bit1, C=bit0. Every flag bit that is clear in `upd_mask` equals the same bit of the request's `flags_in`. Unless a requirement says otherwise, N is bit 7 of the result and Z is set when the result is 0.
- R3: Add (code 0), add-with-carry (code 1, adds incoming C) and accumulator add (code 2) write `a+b(+C)` and update all five flags. H is the carry out of bit 3, C is the carry out of bit 7, and V is signed overflow. No other code updates H.
- R4: Subtract (code 3), subtract-with-borrow (code 4, subtracts incoming C) and compare (code 5) compute `a-b(-C)`. They update N, Z, V and C, where C is the unsigned borrow and V is signed overflow. Compare does not write the result.
- R5: AND (6), bit-test (7), XOR (8), OR (9) and pass-through of `opb` (10) update N and Z, clear V and leave C unchanged. Bit-test does not write the result.
- R6: Complement (11) writes `0xFF-a`, sets C and clears V.
- R7: Clear (15) writes 0x00 and forces N=0, Z=1, V=0, C=0.
- R8: Test (16) sets N and Z from `a`, forces V=0 and C=0, and does not write the result.
- R9: Increment (13) and decrement (14) update N, Z and V and leave C unchanged. V is set for increment when `a` is 0x7F and for decrement when `a` is 0x80.
- R10: Negate (12) writes `0-a`. It sets C when the result is nonzero and sets V when `a` is 0x80.
- R11: Logical shift right (17) shifts in 0 at bit 7, so N is always 0. Arithmetic shift right (18) keeps bit 7. Shift left (19) shifts in 0 at bit 0. Rotate left (20) and rotate right (21) shift the incoming C in. For the right moves, bit 0 goes to C; for the left moves, bit 7 goes to C. For all five, V = N xor C.
- R12: Decimal adjust (22) adds 0x06 when the low nibble of `a` is above 9 or incoming H is set. It adds 0x60 when incoming C is set, or the high nibble is above 9, or the high nibble is above 8 while the low nibble is above 9. C becomes incoming C OR the upper correction. V is the signed overflow of the correction add. N, Z, V and C are updated.
- R13: Codes 23 to 31 are undefined. They produce `upd_mask`=0 and `wr_en`=0, so all flags pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand (accumulator) |
| opb | input | 8 | Second operand (memory or other accumulator) |
| flags_in | input | 5 | Current condition codes {H,N,Z,V,C} |
| out_valid | output | 1 | Registered result is valid |
| res | output | 8 | Result byte |
| flags_out | output | 5 | New condition codes {H,N,Z,V,C} |
| upd_mask | output | 5 | Flags updated by the operation |
| wr_en | output | 1 | Result byte must be written back |

## Verification
The hardest cases to reach are those where the flag outcome depends on exact operand values. Decimal adjust must see both corrections, including the case where the high nibble is 9 and the low nibble exceeds 9. Negate and decrement need the 0x80 operand, and increment needs the 0x7F operand. Uniform random bytes rarely produce these values, so directed requests hit each of them. Random requests drawn from a fixed seed then cover the whole code space, including the undefined codes. Random incoming flag bytes show whether the untouched flags really pass through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int OPW = 5;
  localparam int FW = 5;
  localparam int NW = DW / 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_ABA = 5'd2, OP_SUB = 5'd3,
    OP_SBC = 5'd4, OP_CMP = 5'd5, OP_AND = 5'd6, OP_BIT = 5'd7,
    OP_EOR = 5'd8, OP_ORA = 5'd9, OP_PASS = 5'd10, OP_COM = 5'd11,
    OP_NEG = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_CLR = 5'd15,
    OP_TST = 5'd16, OP_LSR = 5'd17, OP_ASR = 5'd18, OP_ASL = 5'd19,
    OP_ROL = 5'd20, OP_ROR = 5'd21, OP_DAA = 5'd22
  } op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          use_c,
  output logic [DW-1:0] r,
  output logic          hc,
  output logic          co,
  output logic          ov
);
  logic [DW:0]   sum;
  logic [NW:0]   nsum;
  logic [DW-1:0] bx;
  logic          ci;

  always_comb begin
    bx   = sub ? ~b : b;
    ci   = sub ? ~(use_c & cin) : (use_c & cin);
    sum  = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, ci};
    nsum = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, ci};
    r    = sum[DW-1:0];
    hc   = nsum[NW];
    co   = sub ? ~sum[DW] : sum[DW];
    ov   = (a[DW-1] == bx[DW-1]) && (sum[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  op_e           op,
  output logic [DW-1:0] r
);
  always_comb begin
    case (op)
      OP_AND, OP_BIT: r = a & b;
      OP_EOR:         r = a ^ b;
      OP_ORA:         r = a | b;
      OP_PASS:        r = b;
      default:        r = '0;
    endcase
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  op_e           op,
  output logic [DW-1:0] r,
  output logic          co,
  output logic          ov
);
  localparam logic [DW-1:0] MINNEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    r  = a;
    co = cin;
    ov = 1'b0;
    case (op)
      OP_COM: begin r = ~a; co = 1'b1; end
      OP_NEG: begin r = '0 - a; co = (a != '0); ov = (a == MINNEG); end
      OP_INC: begin r = a + 1'b1; ov = (a == MAXPOS); end
      OP_DEC: begin r = a - 1'b1; ov = (a == MINNEG); end
      OP_CLR: begin r = '0; co = 1'b0; end
      OP_TST: begin r = a; co = 1'b0; end
      OP_LSR: begin r = {1'b0, a[DW-1:1]}; co = a[0]; end
      OP_ASR: begin r = {a[DW-1], a[DW-1:1]}; co = a[0]; end
      OP_ASL: begin r = {a[DW-2:0], 1'b0}; co = a[DW-1]; end
      OP_ROL: begin r = {a[DW-2:0], cin}; co = a[DW-1]; end
      OP_ROR: begin r = {cin, a[DW-1:1]}; co = a[0]; end
      default: ;
    endcase
    if (op inside {OP_LSR, OP_ASR, OP_ASL, OP_ROL, OP_ROR})
      ov = r[DW-1] ^ co;
  end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          hin,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          co,
  output logic          ov
);
  logic [NW-1:0] lo, hi;
  logic          fix_lo, fix_hi;
  logic [DW-1:0] corr;

  always_comb begin
    lo     = a[NW-1:0];
    hi     = a[DW-1:NW];
    fix_lo = hin || (lo > 4'd9);
    fix_hi = cin || (hi > 4'd9) || ((hi > 4'd8) && (lo > 4'd9));
    corr   = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
    r      = a + corr;
    co     = cin | fix_hi;
    ov     = (a[DW-1] == corr[DW-1]) && (r[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [FW-1:0]  flags_in,
  output logic           out_valid,
  output logic [DW-1:0]  res,
  output logic [FW-1:0]  flags_out,
  output logic [FW-1:0]  upd_mask,
  output logic           wr_en
);
  localparam logic [FW-1:0] M_ALL  = 5'b11111;
  localparam logic [FW-1:0] M_NZVC = 5'b01111;
  localparam logic [FW-1:0] M_NZV  = 5'b01110;

  op_e    opc;
  flags_t fin;
  assign opc = op_e'(op);
  assign fin = flags_t'(flags_in);

  logic [DW-1:0] as_r, lg_r, un_r, bc_r;
  logic          as_h, as_c, as_v, un_c, un_v, bc_c, bc_v;
  logic          is_sub, is_carry;

  assign is_sub   = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_CMP);
  assign is_carry = (opc == OP_ADC) || (opc == OP_SBC);

  alu8_addsub u_addsub (
    .a(opa), .b(opb), .cin(fin.c), .sub(is_sub), .use_c(is_carry),
    .r(as_r), .hc(as_h), .co(as_c), .ov(as_v)
  );
  alu8_logic u_logic (.a(opa), .b(opb), .op(opc), .r(lg_r));
  alu8_unary u_unary (
    .a(opa), .cin(fin.c), .op(opc), .r(un_r), .co(un_c), .ov(un_v)
  );
  alu8_bcd u_bcd (
    .a(opa), .hin(fin.h), .cin(fin.c), .r(bc_r), .co(bc_c), .ov(bc_v)
  );

  logic [DW-1:0] r_c;
  flags_t        f_c;
  logic [FW-1:0] m_c;
  logic          w_c;

  always_comb begin
    r_c = '0;
    f_c = fin;
    m_c = '0;
    w_c = 1'b0;
    case (opc)
      OP_ADD, OP_ADC, OP_ABA: begin
        r_c = as_r; f_c.h = as_h; f_c.c = as_c; f_c.v = as_v;
        m_c = M_ALL; w_c = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r_c = as_r; f_c.c = as_c; f_c.v = as_v;
        m_c = M_NZVC; w_c = (opc != OP_CMP);
      end
      OP_AND, OP_BIT, OP_EOR, OP_ORA, OP_PASS: begin
        r_c = lg_r; f_c.v = 1'b0;
        m_c = M_NZV; w_c = (opc != OP_BIT);
      end
      OP_INC, OP_DEC: begin
        r_c = un_r; f_c.v = un_v;
        m_c = M_NZV; w_c = 1'b1;
      end
      OP_COM, OP_NEG, OP_CLR, OP_TST, OP_LSR, OP_ASR, OP_ASL, OP_ROL, OP_ROR: begin
        r_c = un_r; f_c.c = un_c; f_c.v = un_v;
        m_c = M_NZVC; w_c = (opc != OP_TST);
      end
      OP_DAA: begin
        r_c = bc_r; f_c.c = bc_c; f_c.v = bc_v;
        m_c = M_NZVC; w_c = 1'b1;
      end
      default: ;
    endcase
    f_c.n = r_c[DW-1];
    f_c.z = (r_c == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      flags_out <= '0;
      upd_mask  <= '0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res       <= r_c;
        flags_out <= (FW'(f_c) & m_c) | (flags_in & ~m_c);
        upd_mask  <= m_c;
        wr_en     <= w_c;
      end else begin
        upd_mask  <= '0;
        wr_en     <= 1'b0;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wr_en && upd_mask == '0));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((flags_out ^ $past(flags_in)) & ~upd_mask) == '0));

  assert_half_only_add_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && upd_mask[4]) |-> ($past(op) <= 5'd2));

  assert_flag_only_ops_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(op) == 5'd5 || $past(op) == 5'd7 || $past(op) == 5'd16)) |-> !wr_en);

  assert_clear_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) == 5'd15) |-> (res == '0 && flags_out[3:0] == 4'b0100));

  assert_lsr_positive_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) == 5'd17) |-> !flags_out[3]);

  assert_undef_inert_R13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) > 5'd22) |-> (!wr_en && upd_mask == '0));
endmodule

// File: tb/alu8_cc_tb.sv
module alu8_cc_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [4:0] flags_in = '0;
  logic       out_valid, wr_en;
  logic [7:0] res;
  logic [4:0] flags_out, upd_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu8_cc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .flags_in(flags_in), .out_valid(out_valid), .res(res), .flags_out(flags_out),
    .upd_mask(upd_mask), .wr_en(wr_en)
  );

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // returns {wr, mask[4:0], flags[4:0], res[7:0]}
  function automatic logic [18:0] model(input int o, input int a, input int b, input logic [4:0] f);
    int r = 0, t, s, corr;
    logic h = f[4], n, z, v = f[1], c = f[0];
    logic [4:0] m = 5'b0;
    logic w = 1'b0;
    logic lsb, msb;
    lsb = a[0]; msb = a[7];
    case (o)
      0, 1, 2: begin
        t = a + b + ((o == 1) ? int'(f[0]) : 0);
        s = sgn(a) + sgn(b) + ((o == 1) ? int'(f[0]) : 0);
        h = ((a % 16) + (b % 16) + ((o == 1) ? int'(f[0]) : 0)) > 15;
        c = t > 255; v = (s > 127) || (s < -128); r = t % 256; m = 5'b11111; w = 1;
      end
      3, 4, 5: begin
        t = a - b - ((o == 4) ? int'(f[0]) : 0);
        s = sgn(a) - sgn(b) - ((o == 4) ? int'(f[0]) : 0);
        c = t < 0; v = (s > 127) || (s < -128); r = (t + 512) % 256; m = 5'b01111; w = (o != 5);
      end
      6, 7, 8, 9, 10: begin
        case (o)
          6, 7: r = a & b;
          8: r = a ^ b;
          9: r = a | b;
          default: r = b;
        endcase
        v = 0; m = 5'b01110; w = (o != 7);
      end
      11: begin r = 255 - a; c = 1; v = 0; m = 5'b01111; w = 1; end
      12: begin r = (256 - a) % 256; c = (r != 0); v = (a == 128); m = 5'b01111; w = 1; end
      13: begin r = (a + 1) % 256; v = (a == 127); m = 5'b01110; w = 1; end
      14: begin r = (a + 255) % 256; v = (a == 128); m = 5'b01110; w = 1; end
      15: begin r = 0; c = 0; v = 0; m = 5'b01111; w = 1; end
      16: begin r = a; c = 0; v = 0; m = 5'b01111; w = 0; end
      17, 18, 19, 20, 21: begin
        case (o)
          17: begin r = a / 2; c = lsb; end
          18: begin r = a / 2 + (msb ? 128 : 0); c = lsb; end
          19: begin r = (a * 2) % 256; c = msb; end
          20: begin r = (a * 2) % 256 + int'(f[0]); c = msb; end
          default: begin r = a / 2 + (f[0] ? 128 : 0); c = lsb; end
        endcase
        v = (r >= 128) ^ c; m = 5'b01111; w = 1;
      end
      22: begin
        corr = 0;
        if (f[4] || (a % 16) > 9) corr = corr + 6;
        if (f[0] || (a / 16) > 9 || ((a / 16) > 8 && (a % 16) > 9)) begin
          corr = corr + 96; c = 1;
        end
        r = (a + corr) % 256; v = (sgn(a) + corr) > 127; m = 5'b01111; w = 1;
      end
      default: begin m = 5'b0; w = 0; end
    endcase
    n = (r >= 128); z = (r == 0);
    if (m != 0) begin
      return {w, m, (({h, n, z, v, c} & m) | (f & ~m)), 8'(r)};
    end
    return {w, m, f, 8'(r)};
  endfunction

  function automatic string tag(input int o);
    if (o <= 2) return "R3";
    if (o <= 5) return "R4";
    if (o <= 10) return "R5";
    if (o == 11) return "R6";
    if (o == 12) return "R10";
    if (o <= 14) return "R9";
    if (o == 15) return "R7";
    if (o == 16) return "R8";
    if (o <= 21) return "R11";
    if (o == 22) return "R12";
    return "R13";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int o, input int a, input int b, input logic [4:0] f);
    logic [18:0] e;
    @(negedge clk);
    in_valid = 1; op = 5'(o); opa = 8'(a); opb = 8'(b); flags_in = f;
    @(negedge clk);
    in_valid = 0;
    e = model(o, a, b, f);
    check("R2", 32'(out_valid), 32'd1);
    check(tag(o), {13'b0, wr_en, upd_mask, flags_out, (e[18] ? res : e[7:0])}, {13'b0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {22'b0, out_valid, wr_en, upd_mask, flags_out, res}, 32'd0);
    rst = 0;
    // directed corners
    run_op(0, 8'h08, 8'h08, 5'b00000);
    run_op(0, 8'h7F, 8'h01, 5'b00000);
    run_op(1, 8'hFF, 8'h00, 5'b00001);
    run_op(2, 8'h80, 8'h80, 5'b10000);
    run_op(3, 8'h80, 8'h01, 5'b10000);
    run_op(4, 8'h00, 8'h00, 5'b00001);
    run_op(5, 8'h42, 8'h42, 5'b10011);
    run_op(7, 8'hF0, 8'h0F, 5'b00011);
    run_op(10, 8'h00, 8'h80, 5'b00011);
    run_op(11, 8'h00, 8'h00, 5'b00010);
    run_op(12, 8'h80, 8'h00, 5'b00000);
    run_op(12, 8'h00, 8'h00, 5'b00011);
    run_op(13, 8'h7F, 8'h00, 5'b00001);
    run_op(14, 8'h80, 8'h00, 5'b00000);
    run_op(14, 8'h00, 8'h00, 5'b00001);
    run_op(15, 8'h5A, 8'h00, 5'b11011);
    run_op(16, 8'h80, 8'h00, 5'b00011);
    run_op(17, 8'h01, 8'h00, 5'b01000);
    run_op(18, 8'h81, 8'h00, 5'b00000);
    run_op(19, 8'h80, 8'h00, 5'b00000);
    run_op(20, 8'h40, 8'h00, 5'b00001);
    run_op(21, 8'h01, 8'h00, 5'b00001);
    run_op(22, 8'h9A, 8'h00, 5'b00000);
    run_op(22, 8'h0F, 8'h00, 5'b10000);
    run_op(22, 8'h12, 8'h00, 5'b00001);
    run_op(22, 8'h45, 8'h00, 5'b00000);
    run_op(25, 8'h33, 8'h44, 5'b10101);
    // idle cycle after a request
    @(negedge clk);
    check("R1", {30'b0, out_valid, wr_en}, 32'd0);
    check("R1", 32'(upd_mask), 32'd0);
    // random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      run_op(int'($urandom % 32), int'($urandom % 256), int'($urandom % 256), 5'($urandom));
      if (i % 100 == 0) begin
        @(negedge clk);
        check("R1", {27'b0, out_valid, upd_mask} | {31'b0, wr_en}, 32'd0);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule